// File: doc/BRIEF.md
# Three-Phase Stored-Program Core

This block is a very small processor. Instructions and data sit together in one internal memory. Each instruction runs through three phases in turn. The fetch phase reads the word that the program counter points at into the instruction register. The decode phase reads the operand named by the instruction into a data register and steps the program counter. The execute phase does the arithmetic or writes memory. The core has no accumulator. A load fills R1. An add first brings its operand into R2 and then writes R1+R2 into R3. A store writes R3 back to memory.

A testbench or a boot agent writes program and data through a preload port. This is normally done while reset is held. The agent then releases reset and the core starts fetching at the address given on `start_addr`. The run ends at a halt instruction, or at any opcode the core does not know. The core then freezes and raises `halted_o` until the next reset. The program counter, the instruction register and R1 to R3 are visible on outputs at all times.

Top module: `fde_core`

## Requirements
- R1: While `rst_n` is low, `pc_o`, `ir_o`, `r1_o`, `r2_o` and `r3_o` are zero and `halted_o` is low. The first fetch after reset is released comes from `start_addr`.
- R2: An instruction word carries its opcode in bits 15:12 and a direct address in bits 11:0. The opcodes are 1 = load, 2 = add, 3 = store and 0 = halt, and the address field of a halt is ignored.
- R3: A load writes the memory word at its address into R1 and leaves R2 and R3 unchanged.
- R4: An add writes the memory word at its address into R2. It then writes (R1+R2) mod 2^16 into R3 and leaves R1 unchanged.
- R5: A store writes R3 into memory at its address and leaves R1, R2 and R3 unchanged.
- R6: Each load, add or store advances the program counter by exactly one. `ir_o` always shows the last word fetched.
- R7: From the first clock edge after `rst_n` rises, the core takes two edges to synchronise reset and one edge to load the start address. After that, a load or an add takes 5 edges, a store takes 4, and a halt word stops the core 3 edges after its fetch begins.
- R8: Once halted, `halted_o` stays high and all registers hold their values until reset. The program counter keeps the address of the halt word.
- R9: An opcode outside 1 to 3 stops the core in the same way as a halt.
- R10: The preload port writes `ld_data` into memory at `ld_addr` on a clock edge with `ld_en` high. Program and data share this memory, so a word that a store writes can later be fetched and run as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_addr | input | 12 | Address of the first instruction after reset |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | 12 | Preload word address |
| ld_data | input | 16 | Preload word |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |
| r1_o | output | 16 | Data register R1 |
| r2_o | output | 16 | Data register R2 |
| r3_o | output | 16 | Data register R3 |
| halted_o | output | 1 | High once a halt or an unknown opcode has been decoded |

## Verification
The bench runs the same five-word program from several start addresses, with sums that wrap past 16 bits. A core that stepped the program counter after execute rather than in decode would give the wrong edge count. A core that dropped the memory read latency would load stale words into R1 or R2. Reading the stored sum back with a load shows whether a store reached memory. A program that stores a computed word into its own next slot and then runs it shows whether fetch and data traffic really share one memory. Unknown opcodes, an immediate halt, and preload writes issued while halted target a core that runs past a stop or keeps changing its registers afterwards.

// File: rtl/fde_pkg.sv
package fde_pkg;
  localparam int OPC_W  = 4;
  localparam int ADR_W  = 12;
  localparam int DATA_W = OPC_W + ADR_W;

  localparam logic [OPC_W-1:0] OPC_HALT = 4'd0;
  localparam logic [OPC_W-1:0] OPC_LDA  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_STO  = 4'd3;

  typedef enum logic [2:0] {
    PH_BOOT,
    PH_FETCH_ADR,
    PH_FETCH_CAP,
    PH_DECODE,
    PH_DEC_CAP,
    PH_EXEC,
    PH_HALT
  } phase_e;
endpackage

// File: rtl/fde_rst_sync.sv
module fde_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fde_mem.sv
module fde_mem #(
  parameter int WIDTH = 16,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
    rdata <= store_q[raddr];
  end
endmodule

// File: rtl/fde_ctrl.sv
module fde_ctrl
  import fde_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_load,
  output logic             pc_inc,
  output logic             ir_we,
  output logic             r1_we,
  output logic             r2_we,
  output logic             r3_we,
  output logic             mem_we,
  output logic             rd_from_ir,
  output logic             halted
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d       = ph_q;
    pc_load    = 1'b0;
    pc_inc     = 1'b0;
    ir_we      = 1'b0;
    r1_we      = 1'b0;
    r2_we      = 1'b0;
    r3_we      = 1'b0;
    mem_we     = 1'b0;
    rd_from_ir = 1'b0;
    unique case (ph_q)
      PH_BOOT: begin
        pc_load = 1'b1;
        ph_d    = PH_FETCH_ADR;
      end
      PH_FETCH_ADR: ph_d = PH_FETCH_CAP;
      PH_FETCH_CAP: begin
        ir_we = 1'b1;
        ph_d  = PH_DECODE;
      end
      PH_DECODE: begin
        if (opcode == OPC_LDA || opcode == OPC_ADD) begin
          rd_from_ir = 1'b1;
          pc_inc     = 1'b1;
          ph_d       = PH_DEC_CAP;
        end else if (opcode == OPC_STO) begin
          pc_inc = 1'b1;
          ph_d   = PH_EXEC;
        end else begin
          ph_d = PH_HALT;
        end
      end
      PH_DEC_CAP: begin
        if (opcode == OPC_LDA) r1_we = 1'b1;
        else                   r2_we = 1'b1;
        ph_d = PH_EXEC;
      end
      PH_EXEC: begin
        if (opcode == OPC_ADD) r3_we  = 1'b1;
        if (opcode == OPC_STO) mem_we = 1'b1;
        ph_d = PH_FETCH_ADR;
      end
      PH_HALT: ph_d = PH_HALT;
      default: ph_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_BOOT;
    else        ph_q <= ph_d;
  end

  assign halted = (ph_q == PH_HALT);

  // R8: once stopped, the sequencer never leaves the halt phase
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R4: the sum is written only right after the operand reached R2
  a_r4_add_order: assert property (@(posedge clk) disable iff (!rst_n)
    r3_we |-> $past(r2_we));

  // R7: after any execute phase the next phase is a fetch
  a_r7_exec_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_EXEC) |=> (ph_q == PH_FETCH_ADR));
endmodule

// File: rtl/fde_regs.sv
module fde_regs
  import fde_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADR_W-1:0]  start_addr,
  input  logic              pc_load,
  input  logic              pc_inc,
  input  logic              ir_we,
  input  logic              r1_we,
  input  logic              r2_we,
  input  logic              r3_we,
  input  logic              halted,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADR_W-1:0]  pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] r1,
  output logic [DATA_W-1:0] r2,
  output logic [DATA_W-1:0] r3
);
  logic [ADR_W-1:0]  pc_d;
  logic [DATA_W-1:0] sum;

  always_comb begin
    pc_d = pc;
    if (pc_load)     pc_d = start_addr;
    else if (pc_inc) pc_d = pc + 1'b1;
  end

  assign sum = r1 + r2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      ir <= '0;
      r1 <= '0;
      r2 <= '0;
      r3 <= '0;
    end else begin
      if (pc_load || pc_inc) pc <= pc_d;
      if (ir_we)             ir <= rdata;
      if (r1_we)             r1 <= rdata;
      if (r2_we)             r2 <= rdata;
      if (r3_we)             r3 <= sum;
    end
  end

  // R6: a decode step moves the program counter by exactly one
  a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> (pc == $past(pc) + 1'b1));

  // R3: R1 is untouched unless the sequencer asks for a load capture
  a_r3_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !r1_we |=> $stable(r1));

  // R8: no register moves while stopped
  a_r8_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc) && $stable(ir) && $stable(r1) && $stable(r2) && $stable(r3)));
endmodule

// File: rtl/fde_core.sv
module fde_core
  import fde_pkg::*;
#(
  parameter int MEM_AW = ADR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADR_W-1:0]  start_addr,
  input  logic              ld_en,
  input  logic [ADR_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [ADR_W-1:0]  pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] r1_o,
  output logic [DATA_W-1:0] r2_o,
  output logic [DATA_W-1:0] r3_o,
  output logic              halted_o
);
  logic rst_n_s;
  logic pc_load, pc_inc, ir_we, r1_we, r2_we, r3_we, mem_we, rd_from_ir, halted;
  logic [ADR_W-1:0]  pc, ir_addr, rd_addr, wr_addr;
  logic [DATA_W-1:0] ir, r1, r2, r3, rdata, wr_data;
  logic              wr_en;

  fde_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  fde_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .opcode(ir[DATA_W-1 -: OPC_W]),
    .pc_load(pc_load), .pc_inc(pc_inc), .ir_we(ir_we),
    .r1_we(r1_we), .r2_we(r2_we), .r3_we(r3_we),
    .mem_we(mem_we), .rd_from_ir(rd_from_ir), .halted(halted)
  );

  fde_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .start_addr(start_addr),
    .pc_load(pc_load), .pc_inc(pc_inc), .ir_we(ir_we),
    .r1_we(r1_we), .r2_we(r2_we), .r3_we(r3_we), .halted(halted),
    .rdata(rdata), .pc(pc), .ir(ir), .r1(r1), .r2(r2), .r3(r3)
  );

  assign ir_addr = ir[ADR_W-1:0];
  assign rd_addr = rd_from_ir ? ir_addr : pc;
  // preload has priority over a store from the core
  assign wr_en   = ld_en | mem_we;
  assign wr_addr = ld_en ? ld_addr : ir_addr;
  assign wr_data = ld_en ? ld_data : r3;

  fde_mem #(.WIDTH(DATA_W), .AW(MEM_AW)) u_mem (
    .clk(clk), .we(wr_en),
    .waddr(wr_addr[MEM_AW-1:0]), .wdata(wr_data),
    .raddr(rd_addr[MEM_AW-1:0]), .rdata(rdata)
  );

  assign pc_o     = pc;
  assign ir_o     = ir;
  assign r1_o     = r1;
  assign r2_o     = r2;
  assign r3_o     = r3;
  assign halted_o = halted;
endmodule

// File: tb/fde_core_bench.sv
module fde_core_bench;
  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] start_addr = '0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [11:0] pc_o;
  logic [15:0] ir_o, r1_o, r2_o, r3_o;
  logic        halted_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  fde_core u_fde_core (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_o(pc_o), .ir_o(ir_o), .r1_o(r1_o), .r2_o(r2_o), .r3_o(r3_o),
    .halted_o(halted_o)
  );

  localparam int NV = 8;
  localparam logic [11:0] V_START [NV] = '{12'h000, 12'h010, 12'h0F8, 12'h123,
                                           12'h200, 12'h2F0, 12'h3F0, 12'h055};
  localparam logic [15:0] V_A [NV] = '{16'h0003, 16'hFFFF, 16'h8000, 16'h1234,
                                       16'h0000, 16'h7FFF, 16'hAAAA, 16'hFFFF};
  localparam logic [15:0] V_B [NV] = '{16'h0004, 16'h0001, 16'h8000, 16'h4321,
                                       16'h0000, 16'h0001, 16'h5555, 16'hFFFF};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [11:0] a, input logic [15:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted_o && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] sum;
    logic [11:0] s;
    logic [15:0] h_ir, h_r1, h_r2, h_r3;
    logic [11:0] h_pc;

    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    chk("R1 pc in reset", pc_o, 0);
    chk("R1 ir in reset", ir_o, 0);
    chk("R1 r1 in reset", r1_o, 0);
    chk("R1 r3 in reset", r3_o, 0);
    chk("R1 halted in reset", halted_o, 0);

    // table: load, add, store, load back, halt (opcode 0 with nonzero address)
    for (int i = 0; i < NV; i++) begin
      rst_n = 1'b0;
      @(negedge clk);
      s = V_START[i];
      load(s,        16'h1300);
      load(s + 12'd1, 16'h2301);
      load(s + 12'd2, 16'h3302);
      load(s + 12'd3, 16'h1302);
      load(s + 12'd4, 16'h0ABC);
      load(12'h300, V_A[i]);
      load(12'h301, V_B[i]);
      load(12'h302, 16'hDEAD);
      start_addr = s;
      run(cyc);
      sum = V_A[i] + V_B[i];
      chk("R7 cycles to halt", cyc, 3 + 5 + 5 + 4 + 5 + 3);
      chk("R3 R5 r1 reloaded sum", r1_o, sum);
      chk("R4 r2 operand", r2_o, V_B[i]);
      chk("R4 r3 sum", r3_o, sum);
      chk("R6 R8 pc at halt word", pc_o, s + 12'd4);
      chk("R2 R6 ir halt word", ir_o, 16'h0ABC);
      chk("R8 halted", halted_o, 1);
    end

    // R1 reset is asynchronous and clears everything
    rst_n = 1'b0;
    #1;
    chk("R1 pc cleared", pc_o, 0);
    chk("R1 r2 cleared", r2_o, 0);
    chk("R1 halted cleared", halted_o, 0);
    @(negedge clk);

    // R9: unknown opcodes stop the core
    for (int k = 0; k < 2; k++) begin
      logic [3:0] op;
      op = (k == 0) ? 4'h7 : 4'hF;
      rst_n = 1'b0;
      @(negedge clk);
      load(12'h040, 16'h1300);
      load(12'h041, {op, 12'h123});
      load(12'h300, 16'h0005);
      start_addr = 12'h040;
      run(cyc);
      chk("R9 cycles", cyc, 3 + 5 + 3);
      chk("R9 halted", halted_o, 1);
      chk("R9 pc", pc_o, 12'h041);
      chk("R9 ir", ir_o, {op, 12'h123});
      chk("R9 r1", r1_o, 16'h0005);
      chk("R9 r3 untouched", r3_o, 0);
    end

    // R10: computed word stored into the next slot and then executed
    rst_n = 1'b0;
    @(negedge clk);
    load(12'h080, 16'h1310);
    load(12'h081, 16'h2311);
    load(12'h082, 16'h3083);
    load(12'h083, 16'h0000);
    load(12'h084, 16'h0000);
    load(12'h310, 16'h1000);
    load(12'h311, 16'h0312);
    load(12'h312, 16'hBEEF);
    start_addr = 12'h080;
    run(cyc);
    chk("R10 cycles", cyc, 3 + 5 + 5 + 4 + 5 + 3);
    chk("R10 r1 from patched load", r1_o, 16'hBEEF);
    chk("R10 r3 patch word", r3_o, 16'h1312);
    chk("R10 pc", pc_o, 12'h084);

    // R8: preload while halted changes no register, halt persists
    h_pc = pc_o; h_ir = ir_o; h_r1 = r1_o; h_r2 = r2_o; h_r3 = r3_o;
    load(12'h084, 16'h1312);
    load(12'h312, 16'h0001);
    repeat (20) @(negedge clk);
    chk("R8 pc frozen", pc_o, h_pc);
    chk("R8 ir frozen", ir_o, h_ir);
    chk("R8 r1 frozen", r1_o, h_r1);
    chk("R8 r2 frozen", r2_o, h_r2);
    chk("R8 r3 frozen", r3_o, h_r3);
    chk("R8 still halted", halted_o, 1);

    // R7 R1: halt as the very first word
    rst_n = 1'b0;
    @(negedge clk);
    load(12'h3A0, 16'h0000);
    start_addr = 12'h3A0;
    run(cyc);
    chk("R7 immediate halt cycles", cyc, 6);
    chk("R1 pc from start_addr", pc_o, 12'h3A0);
    chk("R1 r1 zero", r1_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule